// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches a single pin and, when a chosen kind of transition appears on it, copies the count of one of two free-running 16-bit timers into a 16-bit capture register. Software picks the transition kind and the time base through a small control register. It reads the captured value as two bytes over a plain address/data register bus. Each capture raises a sticky request flag, which is also driven out as an interrupt line.

The timers are not part of the block. Their counts arrive as inputs and must advance in step with the block clock. The pin can be turned into an output through a direction bit. In that case the pin level comes from a port data bit, so a software write that flips this bit is seen by the detector like any external edge and can start a capture. A capture that software has not yet read is overwritten by the next one, and nothing reports the loss.

Top module: `tcap_unit`

## Requirements
- R1: After reset the capture register reads 0, the control register reads 0 (capture disabled, timer A selected, flag clear), the port register reads 0 (pin is an input, data bit 0) and `irq_o` is low.
- R2: Register map: address 0 is the capture low byte and address 1 is the capture high byte, both readable and writable. Address 2 is control: bits 3:0 hold the mode, bit 4 selects the time base and bit 5 is the flag. Address 3 is the port: bit 0 is the data bit and bit 1 is the direction bit (1 means output). Bits that have no function read 0.
- R3: Mode 4'b0100 captures on every falling edge of the pin and on no rising edge.
- R4: Mode 4'b0101 captures on every rising edge of the pin and on no falling edge.
- R5: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th rising edge. Any write to the control register resets the rising-edge count to zero, so the next capture needs a full 4 or 16 new rising edges.
- R6: Any other mode value makes no capture. The capture register and the flag stay unchanged.
- R7: Control bit 4 = 0 captures `tmr_a_i` and bit 4 = 1 captures `tmr_b_i`.
- R8: When the pin level changes before clock edge k, the captured count is the value the selected timer input holds between edges k+1 and k+2. The capture register holds it from edge k+2 on.
- R9: Each capture sets the flag (`irq_o`). The flag stays set until a control write with bit 5 = 0. A control write with bit 5 = 1 leaves it unchanged. If a capture and a clearing write fall in the same cycle, the flag ends up set.
- R10: A later capture overwrites an unread earlier capture with no other indication.
- R11: If a bus write to a capture byte and a capture fall in the same cycle, the register holds the captured timer value.
- R12: With the direction bit at 1, `pad_i` is ignored. The pin level seen by the detector is the port data bit, so writing a changed data bit can cause a capture. `pad_o` always follows the data bit and `pad_oe` the direction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tmr_a_i | input | 16 | Count of time base A |
| tmr_b_i | input | 16 | Count of time base B |
| pad_i | input | 1 | External pin level |
| pad_o | output | 1 | Pin drive value (port data bit) |
| pad_oe | output | 1 | Pin output enable (direction bit) |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| irq_o | output | 1 | Sticky capture request flag |

## Verification
All sixteen mode values are swept with both time-base settings. Each run drives twenty alternating rising and falling pin transitions, and the expected capture after every transition comes from a count of rising edges. This separates falling-edge, rising-edge and the two prescaled modes from each other and from the disabled codes. It also shows whether the stored value is timer A or timer B, offset by exactly two cycles. Directed patterns then place a clearing control write or a capture-byte write in the same cycle as a capture. They rewrite the mode in the middle of a prescale count, and they toggle the port data bit while the external pin is held at the opposite level, which shows whether the output path or the pad drives the detector.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  localparam int DW = 8;
  localparam int AW = 2;

  localparam logic [AW-1:0] ADDR_CAP_LO = 2'd0;
  localparam logic [AW-1:0] ADDR_CAP_HI = 2'd1;
  localparam logic [AW-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [AW-1:0] ADDR_PORT   = 2'd3;

  localparam int CTRL_TSEL_BIT = 4;
  localparam int CTRL_FLAG_BIT = 5;
  localparam int PORT_DATA_BIT = 0;
  localparam int PORT_DIR_BIT  = 1;

  localparam logic [3:0] MODE_FALL    = 4'b0100;
  localparam logic [3:0] MODE_RISE    = 4'b0101;
  localparam logic [3:0] MODE_RISE_LO = 4'b0110;
  localparam logic [3:0] MODE_RISE_HI = 4'b0111;

  typedef enum logic [2:0] {
    EV_OFF,
    EV_FALL,
    EV_RISE,
    EV_RISE_LO,
    EV_RISE_HI
  } ev_kind_t;

  function automatic ev_kind_t decode_mode(input logic [3:0] m);
    case (m)
      MODE_FALL:    return EV_FALL;
      MODE_RISE:    return EV_RISE;
      MODE_RISE_LO: return EV_RISE_LO;
      MODE_RISE_HI: return EV_RISE_HI;
      default:      return EV_OFF;
    endcase
  endfunction

endpackage

// File: rtl/tcap_pin_sync.sv
module tcap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;
  logic              level;

  // synchronizer chain, one stage per flop
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_i};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign level  = chain_q[STAGES-1];
  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;

  // R8: a detected edge is a level change over exactly one cycle
  a_r8_edge_is_change: assert property (@(posedge clk) disable iff (!rst_n)
    (level != prev_q) |=> (prev_q == $past(level)));

endmodule

// File: rtl/tcap_event_gen.sv
module tcap_event_gen
  import tcap_pkg::*;
#(
  parameter int PRESC_LO = 4,
  parameter int PRESC_HI = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic       mode_wr_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       evt_o
);

  localparam int CW = $clog2(PRESC_HI);
  localparam logic [CW-1:0] LIM_LO = CW'(PRESC_LO - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(PRESC_HI - 1);

  ev_kind_t      kind;
  logic          presc_mode;
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_limit;

  always_comb begin
    kind       = decode_mode(mode_i);
    presc_mode = (kind == EV_RISE_LO) || (kind == EV_RISE_HI);
    limit      = (kind == EV_RISE_LO) ? LIM_LO : LIM_HI;
    at_limit   = (cnt_q == limit);
  end

  // prescale count: cleared by any control write, wraps on the Nth rise
  always_comb begin
    cnt_d = cnt_q;
    if (mode_wr_i || !presc_mode) begin
      cnt_d = '0;
    end else if (rise_i) begin
      cnt_d = at_limit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    case (kind)
      EV_FALL:    evt_o = fall_i;
      EV_RISE:    evt_o = rise_i;
      EV_RISE_LO,
      EV_RISE_HI: evt_o = rise_i && at_limit && !mode_wr_i;
      default:    evt_o = 1'b0;
    endcase
  end

  // R6: disabled codes never produce an event
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_OFF) |-> !evt_o);

  // R5: a control write restarts the count
  a_r5_wr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (cnt_q == '0));

  // R5: a prescaled event restarts the count
  a_r5_wrap_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && presc_mode) |=> (cnt_q == '0));

  // R3: falling-edge mode ignores rising edges
  a_r3_no_rise_event: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_FALL && !fall_i) |-> !evt_o);

endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          evt_i,
  output logic [3:0]    mode_o,
  output logic          ctrl_wr_o,
  output logic          port_data_o,
  output logic          port_dir_o,
  output logic          flag_o
);

  logic [TW-1:0] cap_q, cap_d;
  logic [3:0]    mode_q, mode_d;
  logic          tsel_q, tsel_d;
  logic          flag_q, flag_d;
  logic          pdat_q, pdat_d;
  logic          pdir_q, pdir_d;
  logic [TW-1:0] sel_tmr;
  logic          wr_lo, wr_hi, wr_ctrl, wr_port;
  logic          clr_req;
  logic          unused_wbits;

  always_comb begin
    wr_lo   = wr_i && (addr_i == ADDR_CAP_LO);
    wr_hi   = wr_i && (addr_i == ADDR_CAP_HI);
    wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
    wr_port = wr_i && (addr_i == ADDR_PORT);
    clr_req = wr_ctrl && !wdata_i[CTRL_FLAG_BIT];
    sel_tmr = tsel_q ? tmr_b_i : tmr_a_i;
  end

  // next state; a capture has priority over bus writes and clears
  always_comb begin
    cap_d  = cap_q;
    mode_d = mode_q;
    tsel_d = tsel_q;
    flag_d = flag_q;
    pdat_d = pdat_q;
    pdir_d = pdir_q;
    if (wr_lo) cap_d[DW-1:0]  = wdata_i;
    if (wr_hi) cap_d[TW-1:DW] = wdata_i;
    if (wr_ctrl) begin
      mode_d = wdata_i[3:0];
      tsel_d = wdata_i[CTRL_TSEL_BIT];
    end
    if (clr_req) flag_d = 1'b0;
    if (wr_port) begin
      pdat_d = wdata_i[PORT_DATA_BIT];
      pdir_d = wdata_i[PORT_DIR_BIT];
    end
    if (evt_i) begin
      cap_d  = sel_tmr;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      mode_q <= '0;
      tsel_q <= 1'b0;
      flag_q <= 1'b0;
      pdat_q <= 1'b0;
      pdir_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      mode_q <= mode_d;
      tsel_q <= tsel_d;
      flag_q <= flag_d;
      pdat_q <= pdat_d;
      pdir_q <= pdir_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CAP_LO: rdata_o = cap_q[DW-1:0];
      ADDR_CAP_HI: rdata_o = cap_q[TW-1:DW];
      ADDR_CTRL: begin
        rdata_o[3:0]           = mode_q;
        rdata_o[CTRL_TSEL_BIT] = tsel_q;
        rdata_o[CTRL_FLAG_BIT] = flag_q;
      end
      default: begin
        rdata_o[PORT_DATA_BIT] = pdat_q;
        rdata_o[PORT_DIR_BIT]  = pdir_q;
      end
    endcase
  end

  assign mode_o       = mode_q;
  assign ctrl_wr_o    = wr_ctrl;
  assign port_data_o  = pdat_q;
  assign port_dir_o   = pdir_q;
  assign flag_o       = flag_q;
  assign unused_wbits = ^wdata_i[DW-1:CTRL_FLAG_BIT+1];

  // R7 / R11: an event loads the selected timer, whatever the bus does
  a_r11_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (cap_q == $past(tsel_q ? tmr_b_i : tmr_a_i)));

  // R9: an event always leaves the flag set
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q);

  // R9: only a clearing control write drops the flag
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_i && addr_i == ADDR_CTRL && !wdata_i[CTRL_FLAG_BIT])) |=> flag_q);

  // R9: the flag never rises without an event
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !evt_i) |=> !flag_q);

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_LO    = 4,
  parameter int PRESC_HI    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          pad_i,
  output logic          pad_o,
  output logic          pad_oe,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);

  logic       pin_level;
  logic       rise, fall;
  logic       evt;
  logic [3:0] mode;
  logic       ctrl_wr;
  logic       port_data, port_dir;

  // an output-driven pin is observed through its own data bit
  assign pin_level = port_dir ? port_data : pad_i;

  tcap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_level),
    .rise_o (rise),
    .fall_o (fall)
  );

  tcap_event_gen #(.PRESC_LO(PRESC_LO), .PRESC_HI(PRESC_HI)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .mode_wr_i (ctrl_wr),
    .rise_i    (rise),
    .fall_i    (fall),
    .evt_o     (evt)
  );

  tcap_regs #(.TW(TW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (bus_addr),
    .wr_i        (bus_wr),
    .wdata_i     (bus_wdata),
    .rdata_o     (bus_rdata),
    .tmr_a_i     (tmr_a_i),
    .tmr_b_i     (tmr_b_i),
    .evt_i       (evt),
    .mode_o      (mode),
    .ctrl_wr_o   (ctrl_wr),
    .port_data_o (port_data),
    .port_dir_o  (port_dir),
    .flag_o      (irq_o)
  );

  assign pad_o  = port_data;
  assign pad_oe = port_dir;

  // R12: pin drive follows the port register
  a_r12_pad_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_PORT) |=> (pad_oe == $past(bus_wdata[PORT_DIR_BIT])));

endmodule

// File: tb/tb_tcap_unit.sv
module tb_tcap_unit;

  logic        clk;
  logic        rst_n;
  logic [15:0] tcnt;
  logic [15:0] tmr_a, tmr_b;
  logic        pad_i;
  logic        pad_o, pad_oe;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq_o;

  int nchecks = 0;
  int nerr    = 0;
  bit done    = 0;

  tcap_unit dut (
    .clk(clk), .rst_n(rst_n), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_ff @(posedge clk) tcnt <= tcnt + 16'd1;
  assign tmr_a = tcnt;
  assign tmr_b = tcnt ^ 16'h5A5A;

  function automatic logic [15:0] sel_val(input logic ts, input logic [15:0] t);
    return ts ? (t ^ 16'h5A5A) : t;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_cap(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  // change the pad at a falling clock edge; returns the count seen then
  task automatic drive_pad(input logic v, output logic [15:0] t);
    @(negedge clk);
    pad_i = v;
    t = tcnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v, t, exp_cap;
    logic        exp_flag;
    int          rc;
    rst_n = 1'b0; tcnt = 16'h1234; pad_i = 1'b0;
    bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd_cap(v);       check("R1 capture", v, 16'h0000);
    rd(2'd2, d);     check("R1 control", {8'h0, d}, 16'h0000);
    rd(2'd3, d);     check("R1 port", {8'h0, d}, 16'h0000);
    check("R1 irq", {15'h0, irq_o}, 16'h0);
    check("R1 pad_oe", {15'h0, pad_oe}, 16'h0);

    // R2: register read-back
    wr(2'd0, 8'hC3); wr(2'd1, 8'h3C);
    rd_cap(v); check("R2 capture bytes", v, 16'h3CC3);
    wr(2'd2, 8'hDF);
    rd(2'd2, d); check("R2 control bits", {8'h0, d}, 16'h001F);

    // sweep: every mode code, both time bases
    for (int ts = 0; ts < 2; ts++) begin
      for (int m = 0; m < 16; m++) begin
        string tag;
        if (m == 4) tag = "R3";
        else if (m == 5) tag = "R4";
        else if (m == 6 || m == 7) tag = "R5";
        else tag = "R6";
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd2, {3'b000, ts[0], m[3:0]});
        exp_cap = 16'h0000; exp_flag = 1'b0; rc = 0;
        for (int k = 0; k < 20; k++) begin
          bit hit;
          drive_pad(1'b1, t);
          rc++;
          hit = (m == 5) || (m == 6 && rc % 4 == 0) || (m == 7 && rc % 16 == 0);
          if (hit) begin exp_cap = sel_val(ts[0], t + 16'd2); exp_flag = 1'b1; end
          repeat (3) @(negedge clk);
          rd_cap(v);
          check({tag, " R7 R8 R10 rise capture"}, v, exp_cap);
          check({tag, " R9 rise flag"}, {15'h0, irq_o}, {15'h0, exp_flag});
          drive_pad(1'b0, t);
          if (m == 4) begin exp_cap = sel_val(ts[0], t + 16'd2); exp_flag = 1'b1; end
          repeat (3) @(negedge clk);
          rd_cap(v);
          check({tag, " R7 R8 R10 fall capture"}, v, exp_cap);
          check({tag, " R9 fall flag"}, {15'h0, irq_o}, {15'h0, exp_flag});
        end
      end
    end

    // R9: writing 1 to the flag bit keeps it, writing 0 clears it
    wr(2'd2, 8'h05);
    drive_pad(1'b1, t);
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h25);
    check("R9 flag kept by write of 1", {15'h0, irq_o}, 16'h1);
    wr(2'd2, 8'h05);
    check("R9 flag cleared by write of 0", {15'h0, irq_o}, 16'h0);

    // R9: clearing write in the capture cycle loses to the capture
    drive_pad(1'b0, t);
    repeat (3) @(negedge clk);
    drive_pad(1'b1, t);
    @(negedge clk);
    wr(2'd2, 8'h05);
    check("R9 set wins over clear", {15'h0, irq_o}, 16'h1);
    rd_cap(v); check("R9 capture with clear", v, t + 16'd2);

    // R11: capture byte write in the capture cycle loses
    drive_pad(1'b0, t);
    repeat (3) @(negedge clk);
    drive_pad(1'b1, t);
    @(negedge clk);
    wr(2'd0, 8'hEE);
    rd_cap(v); check("R11 capture wins over write", v, t + 16'd2);

    // R5: control rewrite restarts the every-4th count
    drive_pad(1'b0, t);
    wr(2'd2, 8'h06);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    for (int k = 0; k < 2; k++) begin
      drive_pad(1'b1, t); repeat (3) @(negedge clk);
      drive_pad(1'b0, t); repeat (3) @(negedge clk);
    end
    wr(2'd2, 8'h06);
    for (int k = 0; k < 3; k++) begin
      drive_pad(1'b1, t); repeat (3) @(negedge clk);
      drive_pad(1'b0, t); repeat (3) @(negedge clk);
    end
    rd_cap(v); check("R5 no capture after restart", v, 16'h0000);
    drive_pad(1'b1, t); repeat (3) @(negedge clk);
    rd_cap(v); check("R5 4th rise after restart", v, t + 16'd2);
    drive_pad(1'b0, t); repeat (3) @(negedge clk);

    // R12: output direction ignores pad, port write triggers
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd3, 8'h02);
    check("R12 pad_oe", {15'h0, pad_oe}, 16'h1);
    check("R12 pad_o low", {15'h0, pad_o}, 16'h0);
    drive_pad(1'b1, t); repeat (4) @(negedge clk);
    rd_cap(v); check("R12 pad ignored as output", v, 16'h0000);
    check("R12 no flag from pad", {15'h0, irq_o}, 16'h0);
    wr(2'd3, 8'h03);
    t = tcnt;
    check("R12 pad_o high", {15'h0, pad_o}, 16'h1);
    repeat (3) @(negedge clk);
    rd_cap(v); check("R12 port write capture", v, t + 16'd2);
    check("R12 flag from port write", {15'h0, irq_o}, 16'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

endmodule